// File: doc/BRIEF.md
# Spatial Random Dither Reducer

This block narrows 12-bit colour components to a smaller output depth before they leave the display pipeline. It works in one of two ways: it drops the low bits (with optional round-half-up), or it adds pseudo-random noise taken from 28-bit linear feedback shift registers and then drops the low bits. Adding noise before the cut spreads the quantisation error across the frame, so smooth gradients do not show visible bands. The reduced component stays left-aligned in its 12-bit field, and the bits below the kept depth are zero.

Configuration is static. Software turns the enable off, changes the depth, mode and option inputs, and then turns the enable back on. While the enable is low the pixels pass through unchanged. One noise generator can feed all three channels, or each channel can have its own generator with its own feedback tap. The generators can be reseeded at every start of frame, and a 4-bit frame counter is mixed into the seed so that successive frames differ. A high-pass option replaces the noise value with the positive step between consecutive noise samples. For YCbCr 4:2:2 traffic the block only truncates.

Top module: `dither_reducer`

## Requirements
- R1: When cfg_enable is 0, every valid pixel reaches the outputs unchanged, whatever the other configuration inputs are.
- R2: With the enable set, no 4:2:2 and no dither, cfg_round=0 truncates to the kept depth given by cfg_depth: 0 keeps 6 bits, 1 keeps 8 bits and 2 keeps 10 bits. The result is left-aligned in 12 bits with zeros below. cfg_depth=3 passes the pixel unchanged.
- R3: In the same case with cfg_round=1, the block adds half of one output step (2^(11-N) for N kept bits) before truncating. A sum above 4095 saturates to 4095 and is not allowed to wrap.
- R4: When cfg_ycc422=1, cfg_depth 1 or 2 truncates to 8 or 10 bits with rounding and dither ignored. cfg_depth 0 or 3 passes the pixel unchanged.
- R5: Dither (cfg_dither=1, not 4:2:2) applies only at cfg_depth 0 or 1. At cfg_depth 2 or 3 the pixel passes unchanged.
- R6: When dithering, the block takes noise = state[27:16] >> N, adds it to the component, saturates the sum at 4095 and keeps the top N bits.
- R7: Each generator is a Fibonacci LFSR whose next state is {s[26:0], s[27]^s[T-1]}. It is loaded with its seed while rst_n is low, it steps once per valid pixel, and it holds while in_valid is 0.
- R8: When cfg_rgb_rand=0, all three channels take noise from the R generator (T=3). When cfg_rgb_rand=1, R, G and B use generators with T=3, 9 and 13, each seeded from its own seed input.
- R9: With cfg_frame_rand=1, a valid pixel marked with in_sof reloads every generator with seed ^ (frame_count << 8) and uses that reloaded state for its own noise. The 4-bit frame count then increments, wrapping from 15 to 0. A start-of-frame flag on an invalid cycle does nothing. With cfg_frame_rand=0 the count is held at 0 and no reload happens.
- R10: With cfg_highpass=1, the noise becomes max(0, a - b), where a is this pixel's shifted sample and b is the previous valid pixel's sample for the same channel, shifted the same way. The previous sample is 0 after reset.
- R11: The outputs are registered with one cycle of latency. out_valid follows in_valid, out_sof follows in_valid AND in_sof, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the seeds |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of a frame |
| in_r | input | 12 | Red / Cr component |
| in_g | input | 12 | Green / Y component |
| in_b | input | 12 | Blue / Cb component |
| cfg_enable | input | 1 | Reduction enable; 0 = bypass |
| cfg_depth | input | 2 | Depth code 0/1/2 = 6/8/10 kept bits |
| cfg_round | input | 1 | 1 = round half-up before truncation |
| cfg_dither | input | 1 | 1 = random dither instead of truncate/round |
| cfg_ycc422 | input | 1 | 1 = YCbCr 4:2:2 input |
| cfg_rgb_rand | input | 1 | 1 = separate generator per channel |
| cfg_frame_rand | input | 1 | 1 = reseed at each start of frame |
| cfg_highpass | input | 1 | 1 = high-pass noise |
| cfg_seed_r | input | 28 | Seed of the R generator |
| cfg_seed_g | input | 28 | Seed of the G generator |
| cfg_seed_b | input | 28 | Seed of the B generator |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output first pixel of frame |
| out_r | output | 12 | Reduced red / Cr |
| out_g | output | 12 | Reduced green / Y |
| out_b | output | 12 | Reduced blue / Cb |

## Verification
The assertions check, on every cycle, the properties that hold for any input: bypass when disabled, one-cycle forwarding of valid and start-of-frame, zero bits below the kept depth, a generator that holds when no pixel is valid, a frame count cleared when reseeding is off, and a dither or rounding result that never falls below the truncated input. Whether the noise values are actually correct can only be shown by the bench's scenarios. Those scenarios compare outputs against an independent generator model across pixel gaps, shared and per-channel taps, start-of-frame reseeding over more than 16 frames so the counter wraps, and the high-pass difference. The bench also covers fixed truncate and round vectors, the saturation boundary and the depth codes that must pass pixels through.

// File: rtl/dred_pkg.sv
package dred_pkg;

   typedef enum logic [1:0] {
      OP_PASS   = 2'd0,
      OP_TRUNC  = 2'd1,
      OP_ROUND  = 2'd2,
      OP_DITHER = 2'd3
   } dred_op_e;

endpackage

// File: rtl/dred_ctrl.sv
module dred_ctrl
   import dred_pkg::*;
#(
   parameter int PW    = 12,
   parameter int KW    = 4,
   parameter int KEEP0 = 6,
   parameter int KEEP1 = 8,
   parameter int KEEP2 = 10
) (
   input  logic          enable,
   input  logic [1:0]    depth,
   input  logic          round_en,
   input  logic          dither_en,
   input  logic          ycc422,
   output dred_op_e      op,
   output logic [KW-1:0] keep
);

   if (!(KEEP0 > 0 && KEEP0 < KEEP1 && KEEP1 < KEEP2 && KEEP2 < PW)) begin : g_bad_keep
      $error("dred_ctrl: kept depths must rise strictly and stay below PW");
   end
   if ((1 << KW) <= PW) begin : g_bad_kw
      $error("dred_ctrl: KW too narrow for PW");
   end

   always_comb begin
      case (depth)
         2'd0:    keep = KW'(KEEP0);
         2'd1:    keep = KW'(KEEP1);
         default: keep = KW'(KEEP2);
      endcase

      if (!enable) begin
         op = OP_PASS;
      end else if (ycc422) begin
         op = (depth == 2'd1 || depth == 2'd2) ? OP_TRUNC : OP_PASS;
      end else if (dither_en) begin
         op = (depth <= 2'd1) ? OP_DITHER : OP_PASS;
      end else if (depth == 2'd3) begin
         op = OP_PASS;
      end else begin
         op = round_en ? OP_ROUND : OP_TRUNC;
      end
   end

endmodule

// File: rtl/dred_lfsr.sv
module dred_lfsr #(
   parameter int W   = 28,
   parameter int TAP = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] seed,
   input  logic         adv,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cur
);

   logic [W-1:0] state;

   if (TAP < 1 || TAP >= W) begin : g_bad_tap
      $error("dred_lfsr: TAP must lie in 1..W-1");
   end

   assign cur = load ? load_val : state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= seed;
      end else if (adv) begin
         state <= {cur[W-2:0], cur[W-1] ^ cur[TAP-1]};
      end
   end

   AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(state));   // R7

endmodule

// File: rtl/dred_chan.sv
module dred_chan
   import dred_pkg::*;
#(
   parameter int PW = 12,
   parameter int KW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid,
   input  dred_op_e      op,
   input  logic [KW-1:0] keep,
   input  logic          highpass,
   input  logic [PW-1:0] pix,
   input  logic [PW-1:0] raw,
   output logic [PW-1:0] out_pix
);

   localparam logic [KW-1:0] PWK = KW'(PW);

   logic [KW-1:0] shift;
   logic [PW-1:0] mask;
   logic [PW:0]   half;
   logic [PW-1:0] prev;
   logic [PW-1:0] cur_n;
   logic [PW-1:0] prev_n;
   logic [PW-1:0] noise;
   logic [PW:0]   sum_d;
   logic [PW:0]   sum_r;
   logic [PW-1:0] sat_d;
   logic [PW-1:0] sat_r;
   logic [PW-1:0] result;

   always_comb begin
      shift  = PWK - keep;
      mask   = {PW{1'b1}} << shift;
      half   = (PW+1)'(1) << (shift - KW'(1));
      cur_n  = raw >> keep;
      prev_n = prev >> keep;
      if (highpass) begin
         noise = (cur_n > prev_n) ? (cur_n - prev_n) : '0;
      end else begin
         noise = cur_n;
      end
      sum_d = {1'b0, pix} + {1'b0, noise};
      sum_r = {1'b0, pix} + half;
      sat_d = sum_d[PW] ? {PW{1'b1}} : sum_d[PW-1:0];
      sat_r = sum_r[PW] ? {PW{1'b1}} : sum_r[PW-1:0];
      case (op)
         OP_TRUNC:  result = pix & mask;
         OP_ROUND:  result = sat_r & mask;
         OP_DITHER: result = sat_d & mask;
         default:   result = pix;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_pix <= '0;
         prev    <= '0;
      end else if (valid) begin
         out_pix <= result;
         prev    <= raw;
      end
   end

   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op != OP_PASS) |=> ((out_pix & ~$past(mask)) == '0));   // R2
   AST_ROUND_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == OP_ROUND) |=> (out_pix >= $past(pix & mask)));   // R3
   AST_DITHER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && op == OP_DITHER) |=> (out_pix >= $past(pix & mask)));   // R6

endmodule

// File: rtl/dither_reducer.sv
module dither_reducer
   import dred_pkg::*;
#(
   parameter int PIX_W    = 12,
   parameter int LFSR_W   = 28,
   parameter int FC_W     = 4,
   parameter int FC_SHIFT = 8,
   parameter int TAP_R    = 3,
   parameter int TAP_G    = 9,
   parameter int TAP_B    = 13,
   parameter int KEEP0    = 6,
   parameter int KEEP1    = 8,
   parameter int KEEP2    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic [PIX_W-1:0]  in_r,
   input  logic [PIX_W-1:0]  in_g,
   input  logic [PIX_W-1:0]  in_b,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_depth,
   input  logic              cfg_round,
   input  logic              cfg_dither,
   input  logic              cfg_ycc422,
   input  logic              cfg_rgb_rand,
   input  logic              cfg_frame_rand,
   input  logic              cfg_highpass,
   input  logic [LFSR_W-1:0] cfg_seed_r,
   input  logic [LFSR_W-1:0] cfg_seed_g,
   input  logic [LFSR_W-1:0] cfg_seed_b,
   output logic              out_valid,
   output logic              out_sof,
   output logic [PIX_W-1:0]  out_r,
   output logic [PIX_W-1:0]  out_g,
   output logic [PIX_W-1:0]  out_b
);

   localparam int KW    = $clog2(PIX_W + 1);
   localparam int N_CH  = 3;

   if (PIX_W > LFSR_W) begin : g_bad_pix
      $error("dither_reducer: PIX_W must not exceed LFSR_W");
   end
   if (FC_SHIFT + FC_W > LFSR_W) begin : g_bad_fc
      $error("dither_reducer: frame counter does not fit in the seed");
   end

   dred_op_e      op;
   logic [KW-1:0] keep;
   logic [FC_W-1:0] frame_cnt;
   logic          reload;

   logic [LFSR_W-1:0] seed_a [N_CH];
   logic [LFSR_W-1:0] cur_a  [N_CH];
   logic [PIX_W-1:0]  pix_a  [N_CH];
   logic [PIX_W-1:0]  res_a  [N_CH];

   assign seed_a[0] = cfg_seed_r;
   assign seed_a[1] = cfg_seed_g;
   assign seed_a[2] = cfg_seed_b;
   assign pix_a[0]  = in_r;
   assign pix_a[1]  = in_g;
   assign pix_a[2]  = in_b;
   assign out_r     = res_a[0];
   assign out_g     = res_a[1];
   assign out_b     = res_a[2];

   assign reload = in_valid && in_sof && cfg_frame_rand;

   dred_ctrl #(
      .PW(PIX_W), .KW(KW), .KEEP0(KEEP0), .KEEP1(KEEP1), .KEEP2(KEEP2)
   ) i_ctrl (
      .enable   (cfg_enable),
      .depth    (cfg_depth),
      .round_en (cfg_round),
      .dither_en(cfg_dither),
      .ycc422   (cfg_ycc422),
      .op       (op),
      .keep     (keep)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_cnt <= '0;
      end else if (!cfg_frame_rand) begin
         frame_cnt <= '0;
      end else if (in_valid && in_sof) begin
         frame_cnt <= frame_cnt + FC_W'(1);
      end
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      localparam int TAP = (i == 0) ? TAP_R : ((i == 1) ? TAP_G : TAP_B);
      logic [LFSR_W-1:0] load_val;
      logic [LFSR_W-1:0] src;

      assign load_val = seed_a[i] ^ (LFSR_W'(frame_cnt) << FC_SHIFT);

      dred_lfsr #(.W(LFSR_W), .TAP(TAP)) i_lfsr (
         .clk     (clk),
         .rst_n   (rst_n),
         .seed    (seed_a[i]),
         .adv     (in_valid),
         .load    (reload),
         .load_val(load_val),
         .cur     (cur_a[i])
      );

      assign src = cfg_rgb_rand ? cur_a[i] : cur_a[0];

      dred_chan #(.PW(PIX_W), .KW(KW)) i_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .valid   (in_valid),
         .op      (op),
         .keep    (keep),
         .highpass(cfg_highpass),
         .pix     (pix_a[i]),
         .raw     (src[LFSR_W-1 -: PIX_W]),
         .out_pix (res_a[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_sof   <= in_valid && in_sof;
      end
   end

   AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_enable) |=> (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));   // R1
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid) && out_sof == $past(in_valid && in_sof)));   // R11
   AST_FC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_frame_rand |=> (frame_cnt == '0));   // R9

endmodule

// File: tb/test_dither_reducer.sv
`timescale 1ns/1ps
module test_dither_reducer;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_sof;
   logic [11:0] in_r, in_g, in_b;
   logic        cfg_enable, cfg_round, cfg_dither, cfg_ycc422;
   logic [1:0]  cfg_depth;
   logic        cfg_rgb_rand, cfg_frame_rand, cfg_highpass;
   logic [27:0] cfg_seed_r, cfg_seed_g, cfg_seed_b;
   logic        out_valid, out_sof;
   logic [11:0] out_r, out_g, out_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dither_reducer i_dither_reducer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_r(in_r), .in_g(in_g), .in_b(in_b),
      .cfg_enable(cfg_enable), .cfg_depth(cfg_depth), .cfg_round(cfg_round),
      .cfg_dither(cfg_dither), .cfg_ycc422(cfg_ycc422),
      .cfg_rgb_rand(cfg_rgb_rand), .cfg_frame_rand(cfg_frame_rand),
      .cfg_highpass(cfg_highpass),
      .cfg_seed_r(cfg_seed_r), .cfg_seed_g(cfg_seed_g), .cfg_seed_b(cfg_seed_b),
      .out_valid(out_valid), .out_sof(out_sof),
      .out_r(out_r), .out_g(out_g), .out_b(out_b)
   );

   // {en, ycc422, dither, round, depth[1:0], pixel[11:0], expected[11:0]}
   localparam int NV = 15;
   localparam logic [29:0] TBL [NV] = '{
      {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 12'hABC, 12'hABC},
      {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 12'hABC, 12'hA80},
      {1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 12'hABC, 12'hAB0},
      {1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 12'hABF, 12'hABC},
      {1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 12'h123, 12'h123},
      {1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 12'hAB8, 12'hAC0},
      {1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 12'hAB7, 12'hAB0},
      {1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 12'hFE0, 12'hFC0},
      {1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 12'h7FE, 12'h800},
      {1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 12'hFFF, 12'hFFC},
      {1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 12'hAB8, 12'hAB0},
      {1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 12'hABF, 12'hABC},
      {1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 12'hABF, 12'hABF},
      {1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 12'hABF, 12'hABF},
      {1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 12'h5A5, 12'h5A5}
   };

   // independent model of the noise generators
   logic [27:0] m_st   [3];
   logic [11:0] m_prev [3];
   logic [3:0]  m_fc;
   logic        pend_v;
   logic [11:0] pend_e [3];
   string       cur_tag;

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [11:0] get_out(input int ch);
      return (ch == 0) ? out_r : ((ch == 1) ? out_g : out_b);
   endfunction

   function automatic int tap_of(input int ch);
      return (ch == 0) ? 3 : ((ch == 1) ? 9 : 13);
   endfunction

   function automatic logic [11:0] pix_of(input int k, input int ch);
      if (k % 7 == 3) return 12'hFFF;
      return 12'((k * 613 + ch * 1117 + 37) % 4096);
   endfunction

   task automatic model_init();
      m_st[0] = cfg_seed_r;
      m_st[1] = cfg_seed_g;
      m_st[2] = cfg_seed_b;
      for (int i = 0; i < 3; i++) m_prev[i] = '0;
      m_fc = '0;
   endtask

   task automatic model_step(input logic sof, input int k);
      logic [27:0] cur [3];
      logic [27:0] seeds [3];
      int          n;
      seeds[0] = cfg_seed_r;
      seeds[1] = cfg_seed_g;
      seeds[2] = cfg_seed_b;
      n = (cfg_depth == 2'd0) ? 6 : 8;
      for (int i = 0; i < 3; i++)
         cur[i] = (sof && cfg_frame_rand) ? (seeds[i] ^ (28'(m_fc) << 8)) : m_st[i];
      for (int i = 0; i < 3; i++) begin
         logic [27:0] src;
         logic [11:0] raw, a, b, nz, mask;
         logic [12:0] sum;
         src  = cfg_rgb_rand ? cur[i] : cur[0];
         raw  = src[27:16];
         a    = raw >> n;
         b    = m_prev[i] >> n;
         nz   = cfg_highpass ? ((a > b) ? a - b : 12'd0) : a;
         sum  = {1'b0, pix_of(k, i)} + {1'b0, nz};
         if (sum > 13'd4095) sum = 13'd4095;
         mask = 12'hFFF << (12 - n);
         pend_e[i] = sum[11:0] & mask;
         m_prev[i] = raw;
      end
      for (int i = 0; i < 3; i++)
         m_st[i] = {cur[i][26:0], cur[i][27] ^ cur[i][tap_of(i) - 1]};
      if (!cfg_frame_rand) m_fc = '0;
      else if (sof) m_fc = m_fc + 4'd1;
   endtask

   // one cycle: check the result of the previous cycle, then drive a new one
   task automatic cyc(input logic v, input logic sof, input int k);
      @(negedge clk);
      check("R11", {11'd0, out_valid}, {11'd0, pend_v});
      if (pend_v) for (int ch = 0; ch < 3; ch++) check(cur_tag, get_out(ch), pend_e[ch]);
      if (v) model_step(sof, k);
      pend_v   = v;
      in_valid = v;
      in_sof   = sof;
      in_r     = pix_of(k, 0);
      in_g     = pix_of(k, 1);
      in_b     = pix_of(k, 2);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_sof   = 1'b0;
      pend_v   = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_init();
   endtask

   task automatic set_dither(input logic [1:0] d, input logic rgb, input logic fr, input logic hp);
      cfg_enable     = 1'b1;
      cfg_ycc422     = 1'b0;
      cfg_dither     = 1'b1;
      cfg_round      = 1'b0;
      cfg_depth      = d;
      cfg_rgb_rand   = rgb;
      cfg_frame_rand = fr;
      cfg_highpass   = hp;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
      in_r = '0; in_g = '0; in_b = '0;
      cfg_enable = 1'b0; cfg_depth = 2'd0; cfg_round = 1'b0; cfg_dither = 1'b0;
      cfg_ycc422 = 1'b0; cfg_rgb_rand = 1'b0; cfg_frame_rand = 1'b0; cfg_highpass = 1'b0;
      cfg_seed_r = 28'h5A3C0F1; cfg_seed_g = 28'hB7E2194; cfg_seed_b = 28'h1D4F6A3;
      pend_v = 1'b0;
      cur_tag = "R6";
      do_reset();

      // reset state
      @(negedge clk);
      check("R11", {11'd0, out_valid}, 12'd0);
      check("R11", out_r, 12'd0);
      check("R11", out_b, 12'd0);

      // fixed truncate / round / pass-through vectors
      for (int e = 0; e < NV; e++) begin
         string tag;
         cfg_enable = TBL[e][29];
         cfg_ycc422 = TBL[e][28];
         cfg_dither = TBL[e][27];
         cfg_round  = TBL[e][26];
         cfg_depth  = TBL[e][25:24];
         if (!TBL[e][29])      tag = "R1";
         else if (TBL[e][28])  tag = "R4";
         else if (TBL[e][27])  tag = "R5";
         else if (TBL[e][26])  tag = "R3";
         else                  tag = "R2";
         in_r = TBL[e][23:12];
         in_g = TBL[e][23:12];
         in_b = TBL[e][23:12];
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check(tag, out_r, TBL[e][11:0]);
         check(tag, out_g, TBL[e][11:0]);
         check(tag, out_b, TBL[e][11:0]);
      end

      // R5 R6 R7: shared generator, depth 8, with gaps in the stream
      set_dither(2'd1, 1'b0, 1'b0, 1'b0);
      cur_tag = "R6";
      do_reset();
      for (int k = 0; k < 40; k++) cyc(k % 5 != 4, 1'b0, k);
      cyc(1'b0, 1'b0, 0);

      // R8: separate generators, depth 6
      set_dither(2'd0, 1'b1, 1'b0, 1'b0);
      cur_tag = "R8";
      do_reset();
      for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0, k + 3);
      cyc(1'b0, 1'b0, 0);

      // R9: reseed per frame, counter wraps past 15, invalid sof ignored
      set_dither(2'd1, 1'b1, 1'b1, 1'b0);
      cur_tag = "R9";
      do_reset();
      for (int f = 0; f < 18; f++) begin
         cyc(1'b0, 1'b1, 0);
         for (int p = 0; p < 6; p++) cyc(1'b1, p == 0, f * 6 + p);
      end
      cyc(1'b0, 1'b0, 0);

      // R10: high-pass noise with separate generators
      set_dither(2'd1, 1'b1, 1'b0, 1'b1);
      cur_tag = "R10";
      do_reset();
      for (int k = 0; k < 40; k++) cyc(k % 6 != 2, 1'b0, k + 11);
      cyc(1'b0, 1'b0, 0);

      // R10: high-pass with the shared generator at depth 6
      set_dither(2'd0, 1'b0, 1'b0, 1'b1);
      do_reset();
      for (int k = 0; k < 30; k++) cyc(1'b1, 1'b0, k + 5);
      cyc(1'b0, 1'b0, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule